// File: doc/BRIEF.md
# Triple-Redundant Job Sequencer

This block is a small job-sequencing controller built to tolerate single-event upsets. It holds three complete copies of its state register and next-state logic. It also has three separate majority voters, one owned by each copy. Every voter looks at all three register copies, and its result feeds only its own copy's next-state logic and output decode. A wrong value in one register copy, or at one voter output, is outvoted. Because every domain recomputes from a majority each cycle, the wrong copy is rewritten with good state at the next clock edge.

The controller walks a job through five states: idle, load, run, hold and done. It is driven by three control bits: start, pause and finish. The inputs and outputs are triplicated, one bus per domain, so that upstream and downstream logic can keep their own redundancy.

A `mismatch` output is high whenever the three register copies disagree. It is meant for test and fault observation, not for control.

A parameter moves the voter in front of the register. In that variant each copy stores the majority of the three next-state values.

Top module: `tmr_seq_ctrl`

## Requirements
- R1: When `rst` is high at a rising clock edge, all three state copies take the idle code 0. After that edge all three output buses are 3'b000 and `mismatch` is low.
- R2: Field positions and codes are fixed as follows.
  - Input bits: bit0 is start, bit1 is pause, bit2 is finish.
  - State codes: idle 0, load 1, run 2, hold 3, done 4.
  - Output bits: bit0 is busy (load, run or hold), bit1 is stalled (hold), bit2 is complete (done).
  - Transitions: idle goes to load on start. Load goes to run regardless of inputs. Run goes to hold on pause. Hold returns to run once pause is low. Done returns to idle regardless of inputs.
- R3: In run, finish takes priority over pause, so with both bits set the next state is done.
- R4: Each output bus is the decode of its own domain's voted state. With a single register copy corrupted, all three output buses still show the fault-free sequence.
- R5: A register copy that captured a wrong value is rewritten with the correct state at the next rising clock edge.
- R6: A wrong value on one voter output changes only that domain's output bus while the fault lasts, and the bitwise majority of the three buses stays correct. The domain's register copy is correct again one clock after the fault is removed.
- R7: If one domain's input bus differs from the other two for several cycles, all outputs follow the other two domains throughout. The register copies agree again one clock after the inputs realign.
- R8: `mismatch` is high in exactly those cycles in which the three register copies are not all equal.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| in_a | input | 3 | Control bits for domain 0 (start, pause, finish) |
| in_b | input | 3 | Control bits for domain 1 |
| in_c | input | 3 | Control bits for domain 2 |
| out_a | output | 3 | Status bits from domain 0 (busy, stalled, complete) |
| out_b | output | 3 | Status bits from domain 1 |
| out_c | output | 3 | Status bits from domain 2 |
| mismatch | output | 1 | High while the three register copies disagree |

## Verification
The checker assumes that at most one domain is disturbed at any time. It also assumes that a register or voter fault is removed before another one arrives, and that reset itself is never corrupted. Under those conditions it requires two matching register copies and two matching output buses in every cycle. It also requires that a disagreement seen while all three input buses are equal has gone one cycle later. The stimulus keeps within these assumptions:
- It forces one net in one domain for at most one clock edge.
- It skews only the second domain's input bus when testing a long disturbance.
- It separates each fault event from the next by clean cycles with equal inputs.

// File: rtl/tmr_seq_pkg.sv
package tmr_seq_pkg;

  localparam int SW   = 3;  // state code width
  localparam int IN_W = 3;  // control bits per domain
  localparam int OUT_W = 3; // status bits per domain
  localparam int NDOM = 3;  // redundant domains

  localparam int IB_START  = 0;
  localparam int IB_PAUSE  = 1;
  localparam int IB_FINISH = 2;

  typedef enum logic [SW-1:0] {
    ST_IDLE = 3'd0,
    ST_LOAD = 3'd1,
    ST_RUN  = 3'd2,
    ST_HOLD = 3'd3,
    ST_DONE = 3'd4
  } seq_st_e;

  // Two-of-three on a single bit.
  function automatic logic maj_bit(input logic a, input logic b, input logic c);
    return (a & b) | (a & c) | (b & c);
  endfunction

  // Next-state rule; unused codes fall back to idle.
  function automatic logic [SW-1:0] seq_next(input logic [SW-1:0] cur,
                                            input logic [IN_W-1:0] ctl);
    logic [SW-1:0] nx;
    case (seq_st_e'(cur))
      ST_IDLE: nx = ctl[IB_START] ? ST_LOAD : ST_IDLE;
      ST_LOAD: nx = ST_RUN;
      ST_RUN: begin
        if (ctl[IB_FINISH])     nx = ST_DONE;
        else if (ctl[IB_PAUSE]) nx = ST_HOLD;
        else                    nx = ST_RUN;
      end
      ST_HOLD: nx = ctl[IB_PAUSE] ? ST_HOLD : ST_RUN;
      ST_DONE: nx = ST_IDLE;
      default: nx = ST_IDLE;
    endcase
    return nx;
  endfunction

  // Status decode: bit0 busy, bit1 stalled, bit2 complete.
  function automatic logic [OUT_W-1:0] seq_decode(input logic [SW-1:0] cur);
    logic [OUT_W-1:0] o;
    o = '0;
    case (seq_st_e'(cur))
      ST_LOAD: o[0] = 1'b1;
      ST_RUN:  o[0] = 1'b1;
      ST_HOLD: o    = 3'b011;
      ST_DONE: o[2] = 1'b1;
      default: o    = '0;
    endcase
    return o;
  endfunction

endpackage

// File: rtl/tmr_seq_voter.sv
module tmr_seq_voter
  import tmr_seq_pkg::*;
#(
  parameter int W = 3
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic [W-1:0] c,
  output logic [W-1:0] y
);

  for (genvar i = 0; i < W; i++) begin : g_bit
    assign y[i] = maj_bit(a[i], b[i], c[i]);
  end

endmodule

// File: rtl/tmr_seq_domain.sv
module tmr_seq_domain
  import tmr_seq_pkg::*;
#(
  parameter bit MERGED_VOTE = 1'b0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [IN_W-1:0]  in_bus,
  input  logic [SW-1:0]    peer0,
  input  logic [SW-1:0]    peer1,
  input  logic [SW-1:0]    peer2,
  output logic [SW-1:0]    st_q,
  output wire  [SW-1:0]    nxt,
  output logic [OUT_W-1:0] out_bus
);

  // This domain's own voter result, named for observation and fault injection.
  wire [SW-1:0] voted;

  tmr_seq_voter #(.W(SW)) u_vote (
    .a(peer0),
    .b(peer1),
    .c(peer2),
    .y(voted)
  );

  if (MERGED_VOTE) begin : g_merged
    // Peers are next-state values; the register stores their majority.
    assign nxt     = seq_next(st_q, in_bus);
    assign out_bus = seq_decode(st_q);
    always_ff @(posedge clk) begin
      if (rst) st_q <= ST_IDLE;
      else     st_q <= voted;
    end
  end else begin : g_split
    // Peers are register copies; logic runs from the voted state.
    assign nxt     = seq_next(voted, in_bus);
    assign out_bus = seq_decode(voted);
    always_ff @(posedge clk) begin
      if (rst) st_q <= ST_IDLE;
      else     st_q <= nxt;
    end
  end

endmodule

// File: rtl/tmr_seq_ctrl.sv
module tmr_seq_ctrl
  import tmr_seq_pkg::*;
#(
  parameter bit MERGED_VOTE = 1'b0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [IN_W-1:0]  in_a,
  input  logic [IN_W-1:0]  in_b,
  input  logic [IN_W-1:0]  in_c,
  output logic [OUT_W-1:0] out_a,
  output logic [OUT_W-1:0] out_b,
  output logic [OUT_W-1:0] out_c,
  output logic             mismatch
);

  logic [SW-1:0]    st_q [NDOM];
  logic [SW-1:0]    nx_q [NDOM];
  logic [SW-1:0]    peer [NDOM];
  logic [IN_W-1:0]  in_v [NDOM];
  logic [OUT_W-1:0] out_v[NDOM];

  assign in_v[0] = in_a;
  assign in_v[1] = in_b;
  assign in_v[2] = in_c;

  for (genvar k = 0; k < NDOM; k++) begin : g_dom
    assign peer[k] = MERGED_VOTE ? nx_q[k] : st_q[k];

    tmr_seq_domain #(.MERGED_VOTE(MERGED_VOTE)) u_dom (
      .clk    (clk),
      .rst    (rst),
      .in_bus (in_v[k]),
      .peer0  (peer[0]),
      .peer1  (peer[1]),
      .peer2  (peer[2]),
      .st_q   (st_q[k]),
      .nxt    (nx_q[k]),
      .out_bus(out_v[k])
    );
  end

  assign out_a = out_v[0];
  assign out_b = out_v[1];
  assign out_c = out_v[2];

  assign mismatch = (st_q[0] != st_q[1]) || (st_q[1] != st_q[2]);

endmodule

// File: rtl/tmr_seq_ctrl_chk.sv
module tmr_seq_ctrl_chk
  import tmr_seq_pkg::*;
(
  input logic             clk,
  input logic             rst,
  input logic [IN_W-1:0]  in_a,
  input logic [IN_W-1:0]  in_b,
  input logic [IN_W-1:0]  in_c,
  input logic [OUT_W-1:0] out_a,
  input logic [OUT_W-1:0] out_b,
  input logic [OUT_W-1:0] out_c,
  input logic [SW-1:0]    st0,
  input logic [SW-1:0]    st1,
  input logic [SW-1:0]    st2,
  input logic             mismatch
);

  logic rst_d = 1'b0;
  always_ff @(posedge clk) rst_d <= rst;

  logic in_same;
  assign in_same = (in_a == in_b) && (in_b == in_c);

  AST_RESET_IDLE: assert property (@(posedge clk) disable iff (rst)
    rst_d |-> (st0 == ST_IDLE && st1 == ST_IDLE && st2 == ST_IDLE && !mismatch)); // R1

  AST_OUT_TWO_AGREE: assert property (@(posedge clk) disable iff (rst)
    (out_a == out_b) || (out_a == out_c) || (out_b == out_c)); // R4

  AST_STATE_TWO_AGREE: assert property (@(posedge clk) disable iff (rst)
    (st0 == st1) || (st0 == st2) || (st1 == st2)); // R6

  AST_SCRUB_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    (mismatch && in_same) |=> !mismatch); // R5

endmodule

bind tmr_seq_ctrl tmr_seq_ctrl_chk u_chk (
  .clk     (clk),
  .rst     (rst),
  .in_a    (in_a),
  .in_b    (in_b),
  .in_c    (in_c),
  .out_a   (out_a),
  .out_b   (out_b),
  .out_c   (out_c),
  .st0     (st_q[0]),
  .st1     (st_q[1]),
  .st2     (st_q[2]),
  .mismatch(mismatch)
);

// File: tb/tmr_seq_ctrl_tb.sv
module tmr_seq_ctrl_tb;

  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [2:0] in_a = '0, in_b = '0, in_c = '0;
  logic [2:0] out_a, out_b, out_c;
  logic       mismatch;

  int n_chk = 0;
  int n_bad = 0;
  logic [2:0] g_st = 3'd0;   // golden single-copy state
  logic [2:0] frc_val = '0;  // value held by forced nets

  always #(CLK_PERIOD/2) clk = ~clk;

  tmr_seq_ctrl u_dut (
    .clk(clk), .rst(rst),
    .in_a(in_a), .in_b(in_b), .in_c(in_c),
    .out_a(out_a), .out_b(out_b), .out_c(out_c),
    .mismatch(mismatch)
  );

  // Bench-side model, written from the requirement text.
  function automatic logic [2:0] bmaj(logic [2:0] a, logic [2:0] b, logic [2:0] c);
    return (a & b) | (c & (a | b));
  endfunction

  function automatic logic [2:0] gnext(logic [2:0] s, logic [2:0] i);
    if (s == 3'd0) return i[0] ? 3'd1 : 3'd0;
    if (s == 3'd1) return 3'd2;
    if (s == 3'd2) return i[2] ? 3'd4 : (i[1] ? 3'd3 : 3'd2);
    if (s == 3'd3) return i[1] ? 3'd3 : 3'd2;
    return 3'd0;
  endfunction

  function automatic logic [2:0] gdec(logic [2:0] s);
    logic busy, stall, comp;
    busy  = (s >= 3'd1) && (s <= 3'd3);
    stall = (s == 3'd3);
    comp  = (s == 3'd4);
    return {comp, stall, busy};
  endfunction

  task automatic chk(input logic ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic check_outs(input logic [2:0] exp, input string tag);
    chk(out_a == exp, tag, out_a, exp);
    chk(out_b == exp, tag, out_b, exp);
    chk(out_c == exp, tag, out_c, exp);
  endtask

  // One clock: drive inputs, optionally inject a fault, then check after the edge.
  // fault 1: wrong next-state into domain 1's register; fault 2: wrong domain 2 voter output.
  task automatic step(input logic [2:0] ia, input logic [2:0] ib, input logic [2:0] ic,
                      input int fault, input string tag);
    logic [2:0] gn, r0, r1, r2, bad;
    gn  = gnext(g_st, bmaj(ia, ib, ic));
    r0  = gnext(g_st, ia);
    r1  = gnext(g_st, ib);
    r2  = gnext(g_st, ic);
    bad = g_st ^ 3'b010;
    in_a = ia; in_b = ib; in_c = ic;
    if (fault == 1) begin
      frc_val = gn ^ 3'b001;
      r1 = frc_val;
      force u_dut.g_dom[1].u_dom.nxt = frc_val;
    end
    if (fault == 2) begin
      frc_val = bad;
      r2 = gnext(bad, ic);
      force u_dut.g_dom[2].u_dom.voted = frc_val;
      #1;
      chk(out_c == gdec(bad), "R6 faulty bus", out_c, gdec(bad));
      chk(bmaj(out_a, out_b, out_c) == gdec(g_st), "R6 voted buses",
          bmaj(out_a, out_b, out_c), gdec(g_st));
    end
    @(posedge clk);
    #1;
    if (fault == 1) release u_dut.g_dom[1].u_dom.nxt;
    if (fault == 2) release u_dut.g_dom[2].u_dom.voted;
    g_st = gn;
    @(negedge clk);
    check_outs(gdec(gn), tag);
    chk(mismatch == ((r0 != r1) || (r1 != r2)), "R8 mismatch", mismatch,
        (r0 != r1) || (r1 != r2));
  endtask

  task automatic do_reset(input logic [2:0] iv);
    rst = 1'b1;
    in_a = iv; in_b = iv; in_c = iv;
    @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    g_st = 3'd0;
    check_outs(3'b000, "R1 reset outputs");
    chk(mismatch == 1'b0, "R1 reset mismatch", mismatch, 0);
  endtask

  task automatic t_walk();
    do_reset(3'd0);
    step(3'd0, 3'd0, 3'd0, 0, "R2 idle hold");
    step(3'd1, 3'd1, 3'd1, 0, "R2 start");
    step(3'd7, 3'd7, 3'd7, 0, "R2 load ignores");
    step(3'd2, 3'd2, 3'd2, 0, "R2 pause");
    step(3'd2, 3'd2, 3'd2, 0, "R2 hold stays");
    step(3'd0, 3'd0, 3'd0, 0, "R2 resume");
    step(3'd0, 3'd0, 3'd0, 0, "R2 run stays");
    step(3'd4, 3'd4, 3'd4, 0, "R2 finish");
    step(3'd1, 3'd1, 3'd1, 0, "R2 done to idle");
  endtask

  task automatic t_priority();
    do_reset(3'd0);
    step(3'd1, 3'd1, 3'd1, 0, "R3 setup");
    step(3'd0, 3'd0, 3'd0, 0, "R3 setup");
    step(3'd6, 3'd6, 3'd6, 0, "R3 finish over pause");
  endtask

  task automatic t_mid_reset();
    step(3'd1, 3'd1, 3'd1, 0, "R1 setup");
    step(3'd0, 3'd0, 3'd0, 0, "R1 setup");
    do_reset(3'd1);
  endtask

  task automatic t_reg_upset();
    logic [2:0] pat [6];
    int n;
    pat[0] = 3'd1; pat[1] = 3'd0; pat[2] = 3'd2;
    pat[3] = 3'd0; pat[4] = 3'd4; pat[5] = 3'd0;
    do_reset(3'd0);
    n = $urandom_range(1, 6);
    for (int i = 0; i < n; i++) step(pat[i], pat[i], pat[i], 0, "R2 pre-upset");
    step(3'd0, 3'd0, 3'd0, 1, "R4 outputs under upset");
    step(3'd0, 3'd0, 3'd0, 0, "R5 register scrubbed");
    step(3'd1, 3'd1, 3'd1, 1, "R4 second upset");
    step(3'd0, 3'd0, 3'd0, 0, "R5 scrubbed again");
  endtask

  task automatic t_voter_fault();
    do_reset(3'd0);
    step(3'd0, 3'd0, 3'd0, 2, "R6 voter fault");
    step(3'd0, 3'd0, 3'd0, 0, "R6 repaired");
  endtask

  task automatic t_long_disturb();
    do_reset(3'd0);
    step(3'd1, 3'd0, 3'd1, 0, "R7 skewed start");
    step(3'd0, 3'd4, 3'd0, 0, "R7 skewed load");
    step(3'd2, 3'd0, 3'd2, 0, "R7 skewed pause");
    step(3'd2, 3'd5, 3'd2, 0, "R7 skewed hold");
    step(3'd0, 3'd0, 3'd0, 0, "R7 realigned");
    step(3'd0, 3'd0, 3'd0, 0, "R7 steady");
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    n_bad++;
    n_chk++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    @(negedge clk);
    t_walk();
    t_priority();
    t_mid_reset();
    t_reg_upset();
    t_voter_fault();
    t_long_disturb();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

endmodule